// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Controller

This block is the timebase of a tile-based video processor. It keeps a dot counter and a line counter, with a fixed number of dots on every line. A two-bit region input picks which line starts vertical blanking and which line is the pre-render line. After the pre-render line, the line counter returns to zero. The pixel pipeline, the memory fetch sequencer and the host register file all read the dot, the line and the frame parity from this block.

The block owns the vertical-blank status flag, the two sprite status flags and the pending-interrupt output. It also sets the interrupt-enable bit from host writes to the control register. Three timing behaviours are modelled:

- A status read on the dot just before the flag would be set cancels that set.
- Enabling the interrupt while blanking is already in progress raises it late.
- On odd frames with rendering on, one dot is dropped from the pre-render line.

After reset, host register writes are locked out for a fixed number of dots. The block exports that lock as a pin so that the other registers can honour it too.

All pins are plain control and status signals, sampled on the rising clock edge. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `raster_vblank_ctrl`

## Requirements
- R1: The dot counter counts 0 up to DOT_LAST (340 by default). From DOT_LAST it wraps to 0 and the line counter advances by one.
- R2: The region code selects the blanking line and the pre-render line:
  - code 0 uses 241 and 261;
  - code 1 uses 241 and 311;
  - code 2 uses 291 and 311;
  - code 3 acts as code 0.

  The line after the pre-render line is line 0.
- R3: The vblank flag reads 1 from dot 1 of the blanking line. In that same cycle, nmi_pending reads 1 if the interrupt-enable bit is set.
- R4: In the cycle showing dot 1 of the pre-render line, vblank, nmi_pending, spr0_hit and spr_ovf all read 0.
- R5: A status_rd pulse clears nmi_pending on the next edge. If the pulse falls on dot 0 of the blanking line, that frame's vblank flag and interrupt are not set. The following frame sets them normally.
- R6: With region code 0 or 3, show_bg or show_spr high, and odd frame parity, the pre-render line skips dot DOT_LAST-1. Dot DOT_LAST-2 goes directly to DOT_LAST, so the line has one dot fewer. Without these conditions every line has DOT_LAST+1 dots.
- R7: A control write with ctrl_nmi_en at 0 drops nmi_pending on the next edge. A control write with ctrl_nmi_en at 1 while vblank is 1 raises nmi_pending on the next edge.
- R8: regs_unlocked reads 0 until POWERON_DOTS (88974 by default) clock cycles have passed since reset, then reads 1 until the next reset. Control writes made while it reads 0 have no effect.
- R9: frame_odd toggles on the edge that moves the line counter onto the line just before the blanking line.
- R10: Reset sets dot, line, frame_odd, vblank, nmi_pending, spr0_hit, spr_ovf and regs_unlocked to 0, and clears the interrupt-enable bit.
- R11: A pulse on spr0_hit_set or spr_ovf_set sets the matching flag on the next edge. The flag then holds until the pre-render clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region | input | 2 | Region code selecting line counts |
| show_bg | input | 1 | Background rendering enabled |
| show_spr | input | 1 | Sprite rendering enabled |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_nmi_en | input | 1 | Interrupt-enable bit of the control write data |
| status_rd | input | 1 | Status register read strobe |
| spr0_hit_set | input | 1 | Sprite-0 hit detected by the pixel logic |
| spr_ovf_set | input | 1 | Sprite overflow detected by the evaluator |
| dot | output | DOT_W | Current dot within the line |
| line | output | LINE_W | Current line |
| frame_odd | output | 1 | Frame parity |
| vblank | output | 1 | Vertical-blank status flag |
| nmi_pending | output | 1 | Pending interrupt toward the host |
| spr0_hit | output | 1 | Sprite-0 hit status flag |
| spr_ovf | output | 1 | Sprite overflow status flag |
| regs_unlocked | output | 1 | Host register writes are accepted |

## Verification
The frame timing is run under six combinations of region code and rendering bits. Comparing their blanking lines, pre-render lines and pre-render line lengths separates the region decode, the treatment of code 3, and the skip-enable rule: either rendering bit must enable the skip, rendering off must not, and only region codes 0 and 3 may skip. Each pattern runs for two frames, so the short odd pre-render line can be told apart from the full even one. Directed sequences then place control writes and status reads on exact dots. These cover the write lock, the late interrupt raise, the drop on disable, the clear-on-read, and the one-dot read race that cancels a single frame's flag.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {
    REGION_A   = 2'd0,
    REGION_B   = 2'd1,
    REGION_C   = 2'd2,
    REGION_ALT = 2'd3
  } region_e;

  function automatic logic region_skips(input region_e r);
    return (r == REGION_A) || (r == REGION_ALT);
  endfunction

endpackage

// File: rtl/raster_powerup_gate.sv
module raster_powerup_gate #(
  parameter int LIMIT = 88974
) (
  input  logic clk,
  input  logic rst_n,
  output logic unlocked
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt != LIMIT_V)
      cnt <= cnt + CW'(1);
  end

  assign unlocked = (cnt == LIMIT_V);

  assert_unlock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int DOT_LAST = 340,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] vbl_line,
  input  logic [LINE_W-1:0] pre_line,
  input  logic              skip_en,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              frame_odd
);
  localparam logic [DOT_W-1:0] LAST_V = DOT_W'(DOT_LAST);
  localparam logic [DOT_W-1:0] SKIP_V = DOT_W'(DOT_LAST - 2);

  logic              at_end;
  logic              wrap;
  logic              short_line;
  logic [LINE_W-1:0] line_inc;
  logic [LINE_W-1:0] parity_line;

  assign at_end      = (dot == LAST_V);
  assign wrap        = (line >= pre_line);
  assign line_inc    = line + LINE_W'(1);
  assign parity_line = vbl_line - LINE_W'(1);
  assign short_line  = skip_en && frame_odd && (line == pre_line) && (dot == SKIP_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot       <= '0;
      line      <= '0;
      frame_odd <= 1'b0;
    end else if (at_end) begin
      dot <= '0;
      if (wrap) begin
        line <= '0;
      end else begin
        line <= line_inc;
        if (line_inc == parity_line)
          frame_odd <= ~frame_odd;
      end
    end else if (short_line) begin
      dot <= LAST_V;
    end else begin
      dot <= dot + DOT_W'(1);
    end
  end

  assert_dot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_V) |=> (dot == '0));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_V && line >= pre_line) |=> (line == '0));

  assert_odd_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_en && frame_odd && line == pre_line && dot == SKIP_V) |=> (dot == LAST_V));

  assert_parity_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_V && line < pre_line && line + LINE_W'(2) == vbl_line)
      |=> (frame_odd != $past(frame_odd)));

endmodule

// File: rtl/raster_status_flags.sv
module raster_status_flags #(
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] vbl_line,
  input  logic [LINE_W-1:0] pre_line,
  input  logic              unlocked,
  input  logic              ctrl_wr,
  input  logic              ctrl_nmi_en,
  input  logic              status_rd,
  input  logic              spr0_hit_set,
  input  logic              spr_ovf_set,
  output logic              vblank,
  output logic              nmi_pending,
  output logic              spr0_hit,
  output logic              spr_ovf
);
  logic nmi_en;
  logic set_evt;
  logic clr_evt;
  logic set_ok;
  logic wr_ok;
  logic pend_n;

  assign set_evt = (dot == '0) && (line == vbl_line);
  assign clr_evt = (dot == '0) && (line == pre_line);
  assign set_ok  = set_evt && !status_rd;
  assign wr_ok   = ctrl_wr && unlocked;

  always_comb begin
    pend_n = nmi_pending;
    if (set_ok)
      pend_n = nmi_en;
    if (wr_ok) begin
      if (!ctrl_nmi_en)
        pend_n = 1'b0;
      else if (vblank || set_ok)
        pend_n = 1'b1;
    end
    if (status_rd)
      pend_n = 1'b0;
    if (clr_evt)
      pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank      <= 1'b0;
      nmi_pending <= 1'b0;
      nmi_en      <= 1'b0;
      spr0_hit    <= 1'b0;
      spr_ovf     <= 1'b0;
    end else begin
      nmi_pending <= pend_n;
      if (wr_ok)
        nmi_en <= ctrl_nmi_en;
      if (clr_evt) begin
        vblank   <= 1'b0;
        spr0_hit <= 1'b0;
        spr_ovf  <= 1'b0;
      end else begin
        if (set_ok)
          vblank <= 1'b1;
        if (spr0_hit_set)
          spr0_hit <= 1'b1;
        if (spr_ovf_set)
          spr_ovf <= 1'b1;
      end
    end
  end

  assert_vbl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == '0 && line == vbl_line && !status_rd) |=> vblank);

  assert_pre_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == '0 && line == pre_line) |=> (!vblank && !nmi_pending && !spr0_hit && !spr_ovf));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ctrl_wr) |=> !nmi_pending);

  assert_race_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && dot == '0 && line == vbl_line && !vblank) |=> !vblank);

  assert_late_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && unlocked && ctrl_nmi_en && vblank && !status_rd && !(dot == '0 && line == pre_line))
      |=> nmi_pending);

  assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && ctrl_wr) |=> $stable(nmi_en));

endmodule

// File: rtl/raster_vblank_ctrl.sv
module raster_vblank_ctrl #(
  parameter int DOT_LAST     = 340,
  parameter int VBL_A        = 241,
  parameter int PRE_A        = 261,
  parameter int VBL_B        = 241,
  parameter int PRE_B        = 311,
  parameter int VBL_C        = 291,
  parameter int PRE_C        = 311,
  parameter int POWERON_DOTS = 88974,
  parameter int DOT_W        = $clog2(DOT_LAST + 1),
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        region,
  input  logic              show_bg,
  input  logic              show_spr,
  input  logic              ctrl_wr,
  input  logic              ctrl_nmi_en,
  input  logic              status_rd,
  input  logic              spr0_hit_set,
  input  logic              spr_ovf_set,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              frame_odd,
  output logic              vblank,
  output logic              nmi_pending,
  output logic              spr0_hit,
  output logic              spr_ovf,
  output logic              regs_unlocked
);
  import raster_pkg::*;

  region_e           rgn;
  logic [LINE_W-1:0] vbl_line;
  logic [LINE_W-1:0] pre_line;
  logic              skip_en;

  assign rgn = region_e'(region);

  always_comb begin
    unique case (rgn)
      REGION_B: begin
        vbl_line = LINE_W'(VBL_B);
        pre_line = LINE_W'(PRE_B);
      end
      REGION_C: begin
        vbl_line = LINE_W'(VBL_C);
        pre_line = LINE_W'(PRE_C);
      end
      default: begin
        vbl_line = LINE_W'(VBL_A);
        pre_line = LINE_W'(PRE_A);
      end
    endcase
  end

  assign skip_en = region_skips(rgn) && (show_bg || show_spr);

  raster_powerup_gate #(
    .LIMIT(POWERON_DOTS)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (regs_unlocked)
  );

  raster_counter #(
    .DOT_LAST (DOT_LAST),
    .DOT_W    (DOT_W),
    .LINE_W   (LINE_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .vbl_line  (vbl_line),
    .pre_line  (pre_line),
    .skip_en   (skip_en),
    .dot       (dot),
    .line      (line),
    .frame_odd (frame_odd)
  );

  raster_status_flags #(
    .DOT_W  (DOT_W),
    .LINE_W (LINE_W)
  ) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .dot          (dot),
    .line         (line),
    .vbl_line     (vbl_line),
    .pre_line     (pre_line),
    .unlocked     (regs_unlocked),
    .ctrl_wr      (ctrl_wr),
    .ctrl_nmi_en  (ctrl_nmi_en),
    .status_rd    (status_rd),
    .spr0_hit_set (spr0_hit_set),
    .spr_ovf_set  (spr_ovf_set),
    .vblank       (vblank),
    .nmi_pending  (nmi_pending),
    .spr0_hit     (spr0_hit),
    .spr_ovf      (spr_ovf)
  );

endmodule

// File: tb/raster_vblank_ctrl_tb.sv
`timescale 1ns/1ps
module raster_vblank_ctrl_tb;
  localparam int DL = 20;
  localparam int DW = 5;
  localparam int LW = 9;
  localparam int PON = 60;

  typedef struct packed {
    logic [1:0] rgn;
    logic [1:0] ren;
    logic [7:0] vbl;
    logic [7:0] pre;
    logic       skip;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{rgn: 2'd0, ren: 2'b11, vbl: 8'd6, pre: 8'd9,  skip: 1'b1},
    '{rgn: 2'd0, ren: 2'b00, vbl: 8'd6, pre: 8'd9,  skip: 1'b0},
    '{rgn: 2'd1, ren: 2'b01, vbl: 8'd6, pre: 8'd12, skip: 1'b0},
    '{rgn: 2'd2, ren: 2'b10, vbl: 8'd9, pre: 8'd12, skip: 1'b0},
    '{rgn: 2'd3, ren: 2'b10, vbl: 8'd6, pre: 8'd9,  skip: 1'b1},
    '{rgn: 2'd0, ren: 2'b01, vbl: 8'd6, pre: 8'd9,  skip: 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    region = 2'd0;
  logic          show_bg = 1'b0, show_spr = 1'b0;
  logic          ctrl_wr = 1'b0, ctrl_nmi_en = 1'b0, status_rd = 1'b0;
  logic          spr0_hit_set = 1'b0, spr_ovf_set = 1'b0;
  logic [DW-1:0] dot;
  logic [LW-1:0] line;
  logic          frame_odd, vblank, nmi_pending, spr0_hit, spr_ovf, regs_unlocked;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  raster_vblank_ctrl #(
    .DOT_LAST(DL), .VBL_A(6), .PRE_A(9), .VBL_B(6), .PRE_B(12),
    .VBL_C(9), .PRE_C(12), .POWERON_DOTS(PON), .DOT_W(DW), .LINE_W(LW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .region(region), .show_bg(show_bg), .show_spr(show_spr),
    .ctrl_wr(ctrl_wr), .ctrl_nmi_en(ctrl_nmi_en), .status_rd(status_rd),
    .spr0_hit_set(spr0_hit_set), .spr_ovf_set(spr_ovf_set),
    .dot(dot), .line(line), .frame_odd(frame_odd), .vblank(vblank),
    .nmi_pending(nmi_pending), .spr0_hit(spr0_hit), .spr_ovf(spr_ovf),
    .regs_unlocked(regs_unlocked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctrl_wr = 1'b0; status_rd = 1'b0; spr0_hit_set = 1'b0; spr_ovf_set = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic wait_pos(input int l, input int d);
    int n = 0;
    while (!(int'(line) == l && int'(dot) == d) && n < 4000) begin
      step();
      n++;
    end
    if (n >= 4000) chk(1'b0, "R1 position not reached", int'(line), l);
  endtask

  task automatic wait_vbl(input logic lvl);
    int n = 0;
    while (vblank != lvl && n < 4000) begin
      step();
      n++;
    end
    if (n >= 4000) chk(1'b0, "R3 vblank edge not seen", int'(vblank), int'(lvl));
  endtask

  task automatic ctrl_write(input logic en);
    ctrl_nmi_en = en;
    ctrl_wr = 1'b1;
    step();
    ctrl_wr = 1'b0;
  endtask

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);

    // Table of frame-timing vectors
    for (int i = 0; i < 6; i++) begin
      region = VECS[i].rgn;
      show_bg = VECS[i].ren[1];
      show_spr = VECS[i].ren[0];
      do_reset();
      for (int f = 0; f < 2; f++) begin
        int cnt;
        int exp_len;
        wait_vbl(1'b1);
        chk(int'(line) == int'(VECS[i].vbl) && dot == 1, "R2 R3 vblank rise line",
            int'(line), int'(VECS[i].vbl));
        wait_vbl(1'b0);
        chk(int'(line) == int'(VECS[i].pre) && dot == 1, "R2 R4 vblank clear line",
            int'(line), int'(VECS[i].pre));
        chk(frame_odd == (f == 0), "R9 parity on pre-render line", int'(frame_odd), int'(f == 0));
        cnt = 1;
        for (int n = 0; n < 100; n++) begin
          step();
          if (int'(line) == int'(VECS[i].pre)) cnt++;
          else break;
        end
        exp_len = (VECS[i].skip && f == 0) ? DL - 1 : DL;
        chk(cnt == exp_len, "R6 pre-render dots after dot 0", cnt, exp_len);
        chk(line == 0 && dot == 0, "R2 line wraps to 0 after pre-render", int'(line), 0);
      end
    end

    // Directed tests: region 0, rendering off
    region = 2'd0; show_bg = 1'b0; show_spr = 1'b0;
    do_reset();
    chk(dot == 0 && line == 0, "R10 counters after reset", int'(dot) + int'(line), 0);
    chk(!frame_odd && !vblank && !nmi_pending, "R10 flags after reset",
        int'(frame_odd) + int'(vblank) + int'(nmi_pending), 0);
    chk(!spr0_hit && !spr_ovf && !regs_unlocked, "R10 sprite flags and lock after reset",
        int'(spr0_hit) + int'(spr_ovf) + int'(regs_unlocked), 0);

    wait_pos(0, DL);
    step();
    chk(dot == 0 && line == 1, "R1 dot wraps and line advances", int'(line), 1);

    chk(!regs_unlocked, "R8 locked early", int'(regs_unlocked), 0);
    ctrl_write(1'b1);
    wait_pos(6, 0);
    step();
    chk(vblank == 1'b1, "R3 vblank at dot 1", int'(vblank), 1);
    chk(nmi_pending == 1'b0, "R8 locked write ignored", int'(nmi_pending), 0);
    chk(regs_unlocked == 1'b1, "R8 unlocked after power-on dots", int'(regs_unlocked), 1);

    ctrl_write(1'b1);
    chk(nmi_pending == 1'b1, "R7 late raise during vblank", int'(nmi_pending), 1);
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
    chk(nmi_pending == 1'b0, "R5 read clears pending", int'(nmi_pending), 0);
    ctrl_write(1'b1);
    chk(nmi_pending == 1'b1, "R7 re-raise during vblank", int'(nmi_pending), 1);
    ctrl_write(1'b0);
    chk(nmi_pending == 1'b0, "R7 disable drops pending", int'(nmi_pending), 0);

    spr0_hit_set = 1'b1;
    step();
    spr0_hit_set = 1'b0;
    spr_ovf_set = 1'b1;
    step();
    spr_ovf_set = 1'b0;
    step();
    chk(spr0_hit && spr_ovf, "R11 sprite flags set and held",
        int'(spr0_hit) + int'(spr_ovf), 2);
    ctrl_write(1'b1);
    wait_pos(9, 0);
    step();
    chk(!vblank && !nmi_pending && !spr0_hit && !spr_ovf, "R4 pre-render clears all",
        int'(vblank) + int'(nmi_pending) + int'(spr0_hit) + int'(spr_ovf), 0);

    begin
      logic p;
      wait_pos(4, DL);
      p = frame_odd;
      step();
      chk(line == 5 && frame_odd != p, "R9 parity toggles entering line before vblank",
          int'(frame_odd), int'(!p));
    end

    wait_pos(6, 0);
    step();
    chk(vblank && nmi_pending, "R3 interrupt raised with enable set",
        int'(nmi_pending), 1);

    wait_pos(6, 0);
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
    chk(!vblank && !nmi_pending, "R5 race read suppresses set",
        int'(vblank) + int'(nmi_pending), 0);
    wait_pos(6, 8);
    chk(!vblank, "R5 flag stays clear for the frame", int'(vblank), 0);
    wait_pos(6, 1);
    chk(vblank && nmi_pending, "R5 next frame sets normally",
        int'(vblank) + int'(nmi_pending), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule